// File: doc/BRIEF.md
# Parallel Bus Write Engine

This block turns a stream of write requests into transfers on a shared set of output pins, for a peripheral attached to a general-purpose parallel bus. Each request carries an address and a data word and arrives on a valid/ready handshake. The engine places the data in the low lanes of the pin bus and the address directly above it, raises a write strobe, and provides a bus clock that the peripheral uses to capture the transfer. All pin changes happen at falling bus-clock edges, so the peripheral samples stable values on the rising edge.

There are two transfer modes. In the single-cycle mode, address and data share one bus cycle. When starting from idle, one lead-in bus cycle comes first, with the clock running and the strobe low. In the two-cycle mode, the address goes out with the strobe high, and the data follows in the next bus cycle with the strobe low. A queued request starts its address cycle immediately after the previous data cycle. The bus clock can run freely, or it can be gated so that it toggles only during transfers. Its half-period is a programmable number of system clocks.

The address field can be 0, 4, 12 or 20 bits wide and the data field 8, 16, 24 or 32 bits wide. A configuration that does not fit the pins, or that uses 32-bit data together with the bus clock, sets a sticky error. After that, the engine refuses further requests.

Top module: `pbus_write_engine`

## Requirements
- R1: In single-cycle mode (cfgTwoCycle=0) each write occupies one bus cycle with busWr high, and busPins carries the address field and the data field together during that cycle.
- R2: A single-cycle write that starts from idle is preceded by exactly one bus cycle in which the bus clock rises while busWr is low. A single-cycle write that follows another directly has no such cycle.
- R3: In two-cycle mode (cfgTwoCycle=1) a write is an address cycle (busWr high, busPins = address field only) followed at once by a data cycle (busWr low, busPins = data field only).
- R4: In two-cycle mode a queued request starts its address cycle in the bus cycle right after the previous data cycle, and the first rising bus-clock edge of a write from idle already has busWr high.
- R5: With cfgClkOut=1, cfgClkGate=1 and cfgClkDiv nonzero, busClk rises only during bus cycles that belong to a write, and it stays low while the engine is idle.
- R6: With cfgClkGate=0, or with cfgClkDiv=0, busClk runs continuously, including while idle. Each half-period lasts cfgClkDiv+1 system clocks.
- R7: With cfgClkOut=0, busClk stays low. Writes still complete with their normal strobe and pin sequence.
- R8: Data size code d (0..3) selects 8*(d+1) data lanes starting at pin 0. Address size code 0/1/2/3 selects an address field of 0/4/12/20 bits, taken from the low bits of reqAddr and placed starting at the pin just above the data lanes. Pins above both fields are 0.
- R9: If the address width plus the data width exceeds the pin count, or if 32-bit data is selected while cfgClkOut=1, cfgError goes high within one clock and stays high until reset. While cfgError is high, reqReady is low and no write reaches the bus.
- R10: reqReady is low from the acceptance of a request until that write reaches its last bus cycle. Exactly one request is accepted per write, and back-to-back requests produce back-to-back writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddrSize | input | 2 | Address size code (0: none, 1: 4, 2: 12, 3: 20 bits) |
| cfgDataSize | input | 2 | Data size code (8*(code+1) bits) |
| cfgTwoCycle | input | 1 | 1 selects address/data time multiplexing |
| cfgClkOut | input | 1 | 1 drives the bus clock onto busClk |
| cfgClkGate | input | 1 | 1 requests clock gating to active cycles |
| cfgClkDiv | input | DIV_W | Bus clock half-period minus one, in system clocks |
| reqValid | input | 1 | Write request present |
| reqReady | output | 1 | Engine accepts the request this clock |
| reqAddr | input | ADDR_W | Request address |
| reqData | input | PIN_W | Request data |
| busPins | output | PIN_W | Shared address/data pins |
| busWr | output | 1 | Write strobe |
| busClk | output | 1 | Bus clock |
| cfgError | output | 1 | Sticky illegal-configuration flag |

## Verification
A wrong transfer-state value appears on busWr and busPins at the next rising bus-clock edge. For example, a missing lead-in cycle, a data cycle that carries the strobe, or an extra idle cycle between queued writes each change the sequence of (strobe, pins) pairs that the peripheral captures. A gating or phase-counter fault shows up as rising edges while the engine is idle, or as a wrong edge spacing, within one bus period. A lost or doubled pending request appears as a missing or repeated transfer, or as reqReady rising too early, before the engine returns to idle.

// File: rtl/pbw_pkg.sv
package pbw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_WRITE,
    ST_ADDR,
    ST_DATA
  } pbwState_t;

  typedef struct packed {
    logic loadPend;
    logic loadBus;
    logic usePend;
    logic driveAddr;
    logic driveData;
  } pbwStrobe_t;

  function automatic int unsigned addrBits(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 4;
      2'd2:    return 12;
      default: return 20;
    endcase
  endfunction

  function automatic int unsigned dataBits(input logic [1:0] code);
    return 8 * (int'(code) + 1);
  endfunction

endpackage

// File: rtl/pbw_clk_gen.sv
module pbw_clk_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgClkDiv,
  input  logic             cfgClkOut,
  input  logic             cfgClkGate,
  input  logic             busActive,
  output logic             busTick,
  output logic             busClk
);

  logic [DIV_W-1:0] phaseCnt;
  logic             clkInt;
  logic             phaseEnd;
  logic             gateOn;

  assign phaseEnd = (phaseCnt >= cfgClkDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= '0;
      clkInt   <= 1'b0;
    end else if (phaseEnd) begin
      phaseCnt <= '0;
      clkInt   <= ~clkInt;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // bus cycle boundary: end of the high phase, just before the falling edge
  assign busTick = phaseEnd & clkInt;
  assign gateOn  = cfgClkGate & (cfgClkDiv != '0);
  assign busClk  = cfgClkOut & clkInt & (~gateOn | busActive);

  // R6: the internal clock only changes at the end of a phase
  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !phaseEnd |=> $stable(clkInt));

endmodule

// File: rtl/pbw_ctrl.sv
module pbw_ctrl
  import pbw_pkg::*;
#(
  parameter int PIN_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] cfgAddrSize,
  input  logic [1:0] cfgDataSize,
  input  logic       cfgTwoCycle,
  input  logic       cfgClkOut,
  input  logic       busTick,
  input  logic       reqValid,
  output logic       reqReady,
  output pbwStrobe_t strobe,
  output logic       busWr,
  output logic       busActive,
  output logic       cfgError
);

  pbwState_t state, stateNext;
  logic      pend;
  logic      errFlag;
  logic      illegal;
  logic      lastCycle;
  logic      accept;
  logic      work;
  logic      startNow;

  assign illegal = ((addrBits(cfgAddrSize) + dataBits(cfgDataSize)) > PIN_W) ||
                   ((dataBits(cfgDataSize) == PIN_W) && cfgClkOut);

  assign lastCycle = (state == ST_WRITE) || (state == ST_DATA);
  assign reqReady  = !errFlag && !pend &&
                     ((state == ST_IDLE) || (lastCycle && busTick));
  assign accept    = reqValid && reqReady;
  assign work      = pend || accept;
  assign startNow  = busTick && work && ((state == ST_IDLE) || lastCycle);

  always_comb begin
    stateNext = state;
    if (busTick) begin
      case (state)
        ST_IDLE:  if (work) stateNext = cfgTwoCycle ? ST_ADDR : ST_LEAD;
        ST_LEAD:  stateNext = ST_WRITE;
        ST_WRITE: stateNext = !work ? ST_IDLE : (cfgTwoCycle ? ST_ADDR : ST_WRITE);
        ST_ADDR:  stateNext = ST_DATA;
        ST_DATA:  stateNext = !work ? ST_IDLE : (cfgTwoCycle ? ST_ADDR : ST_LEAD);
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pend    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      state   <= stateNext;
      pend    <= (pend || accept) && !startNow;
      errFlag <= errFlag || illegal;
    end
  end

  always_comb begin
    strobe.loadPend  = accept && !startNow;
    strobe.loadBus   = startNow;
    strobe.usePend   = pend;
    strobe.driveAddr = (state == ST_WRITE) || (state == ST_ADDR);
    strobe.driveData = (state == ST_WRITE) || (state == ST_DATA);
  end

  assign busWr     = (state == ST_WRITE) || (state == ST_ADDR);
  assign busActive = (state != ST_IDLE);
  assign cfgError  = errFlag;

  // R3: an address cycle is always followed by its data cycle
  p_data_after_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR && busTick) |=> (state == ST_DATA));

  // R9: the error flag never clears without reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R9: an idle engine with the error set never starts a write
  p_err_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && state == ST_IDLE && !pend) |=> (state == ST_IDLE));

  // R10: an accepted request is either held or already on the bus
  p_accept_tracked_r10: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (pend || state == ST_LEAD || state == ST_ADDR || state == ST_WRITE));

endmodule

// File: rtl/pbw_datapath.sv
module pbw_datapath
  import pbw_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbwStrobe_t        strobe,
  input  logic [1:0]        cfgAddrSize,
  input  logic [1:0]        cfgDataSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [PIN_W-1:0]  reqData,
  output logic [PIN_W-1:0]  busPins
);

  logic [ADDR_W-1:0] pendAddr, busAddr;
  logic [PIN_W-1:0]  pendData, busData;
  int unsigned       aw, dw;
  logic [63:0]       dMask, aMask;
  logic [PIN_W-1:0]  aField, dField;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendData <= '0;
      busAddr  <= '0;
      busData  <= '0;
    end else begin
      if (strobe.loadPend) begin
        pendAddr <= reqAddr;
        pendData <= reqData;
      end
      if (strobe.loadBus) begin
        busAddr <= strobe.usePend ? pendAddr : reqAddr;
        busData <= strobe.usePend ? pendData : reqData;
      end
    end
  end

  always_comb begin
    aw      = addrBits(cfgAddrSize);
    dw      = dataBits(cfgDataSize);
    dMask   = (64'd1 << dw) - 64'd1;
    aMask   = (64'd1 << aw) - 64'd1;
    dField  = PIN_W'(64'(busData) & dMask);
    aField  = PIN_W'((64'(busAddr) & aMask) << dw);
    busPins = (strobe.driveAddr ? aField : '0) | (strobe.driveData ? dField : '0);
  end

  // R8: nothing is driven above the configured fields
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((aw + dw) < PIN_W) |-> ((64'(busPins) >> (aw + dw)) == 64'd0));

endmodule

// File: rtl/pbus_write_engine.sv
module pbus_write_engine
  import pbw_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 20,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cfgAddrSize,
  input  logic [1:0]        cfgDataSize,
  input  logic              cfgTwoCycle,
  input  logic              cfgClkOut,
  input  logic              cfgClkGate,
  input  logic [DIV_W-1:0]  cfgClkDiv,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [PIN_W-1:0]  reqData,
  output logic [PIN_W-1:0]  busPins,
  output logic              busWr,
  output logic              busClk,
  output logic              cfgError
);

  pbwStrobe_t strobe;
  logic       busTick;
  logic       busActive;

  pbw_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk       (clk),
    .rstN      (rstN),
    .cfgClkDiv (cfgClkDiv),
    .cfgClkOut (cfgClkOut),
    .cfgClkGate(cfgClkGate),
    .busActive (busActive),
    .busTick   (busTick),
    .busClk    (busClk)
  );

  pbw_ctrl #(.PIN_W(PIN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgAddrSize(cfgAddrSize),
    .cfgDataSize(cfgDataSize),
    .cfgTwoCycle(cfgTwoCycle),
    .cfgClkOut  (cfgClkOut),
    .busTick    (busTick),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .strobe     (strobe),
    .busWr      (busWr),
    .busActive  (busActive),
    .cfgError   (cfgError)
  );

  pbw_datapath #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgAddrSize(cfgAddrSize),
    .cfgDataSize(cfgDataSize),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .busPins    (busPins)
  );

endmodule

// File: tb/pbus_write_engine_tb.sv
module pbus_write_engine_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  cfgAddrSize, cfgDataSize;
  logic        cfgTwoCycle, cfgClkOut, cfgClkGate;
  logic [3:0]  cfgClkDiv;
  logic        reqValid;
  logic        reqReady;
  logic [19:0] reqAddr;
  logic [31:0] reqData;
  logic [31:0] busPins;
  logic        busWr, busClk, cfgError;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pbus_write_engine u_dut (
    .clk(clk), .rstN(rstN),
    .cfgAddrSize(cfgAddrSize), .cfgDataSize(cfgDataSize),
    .cfgTwoCycle(cfgTwoCycle), .cfgClkOut(cfgClkOut),
    .cfgClkGate(cfgClkGate), .cfgClkDiv(cfgClkDiv),
    .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqData(reqData),
    .busPins(busPins), .busWr(busWr), .busClk(busClk),
    .cfgError(cfgError)
  );

  // record what a peripheral captures on each rising bus clock
  int unsigned edgeTotal = 0;
  logic        recWr   [256];
  logic [31:0] recPins [256];
  time         recTime [256];

  always @(posedge busClk) begin
    recWr[edgeTotal[7:0]]   = busWr;
    recPins[edgeTotal[7:0]] = busPins;
    recTime[edgeTotal[7:0]] = $time;
    edgeTotal = edgeTotal + 1;
  end

  typedef struct packed {
    logic        two;
    logic [1:0]  asz;
    logic [1:0]  dsz;
    logic [19:0] addr;
    logic [31:0] data;
    logic [31:0] expA;
    logic [31:0] expD;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 2'd1, 2'd0, 20'h0005A, 32'h123456C3, 32'h00000A00, 32'h000000C3},
    '{1'b1, 2'd2, 2'd1, 20'hABCDE, 32'hFFFF1357, 32'h0CDE0000, 32'h00001357},
    '{1'b0, 2'd3, 2'd0, 20'hEDCBA, 32'h00000377, 32'h0EDCBA00, 32'h00000077},
    '{1'b1, 2'd0, 2'd2, 20'h12345, 32'hAB123456, 32'h00000000, 32'h00123456},
    '{1'b0, 2'd1, 2'd2, 20'h000F3, 32'h99AABBCC, 32'h03000000, 32'h00AABBCC}
  };

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    reqData  = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (!reqReady) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned base;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqData = '0;
    cfgAddrSize = 2'd0; cfgDataSize = 2'd0; cfgTwoCycle = 1'b0;
    cfgClkOut = 1'b1; cfgClkGate = 1'b1; cfgClkDiv = 4'd1;
    doReset();

    // reset state
    check(reqReady == 1'b1, "R10 reset ready", longint'(reqReady), 1);
    check(busWr == 1'b0 && busPins == 32'd0, "R1 reset bus idle", longint'(busPins), 0);
    check(cfgError == 1'b0, "R9 reset error", longint'(cfgError), 0);

    // vector table, gated clock, one write each
    for (int i = 0; i < 5; i++) begin
      cfgTwoCycle = VECS[i].two;
      cfgAddrSize = VECS[i].asz;
      cfgDataSize = VECS[i].dsz;
      base = edgeTotal;
      doWrite(VECS[i].addr, VECS[i].data);
      waitIdle();
      check(edgeTotal - base == 2, "R5 edge count per write", longint'(edgeTotal - base), 2);
      if (!VECS[i].two) begin
        check(recWr[base[7:0]] == 1'b0, "R2 lead-in strobe low", longint'(recWr[base[7:0]]), 0);
        check(recWr[8'(base + 1)] == 1'b1 &&
              recPins[8'(base + 1)] == (VECS[i].expA | VECS[i].expD),
              "R1 R8 single-cycle pins", longint'(recPins[8'(base + 1)]),
              longint'(VECS[i].expA | VECS[i].expD));
      end else begin
        check(recWr[base[7:0]] == 1'b1 && recPins[base[7:0]] == VECS[i].expA,
              "R3 R8 address cycle", longint'(recPins[base[7:0]]), longint'(VECS[i].expA));
        check(recWr[8'(base + 1)] == 1'b0 && recPins[8'(base + 1)] == VECS[i].expD,
              "R3 R8 data cycle", longint'(recPins[8'(base + 1)]), longint'(VECS[i].expD));
      end
    end

    // R5: gated clock stays quiet while idle
    base = edgeTotal;
    repeat (20) @(negedge clk);
    check(edgeTotal == base, "R5 no idle edges", longint'(edgeTotal - base), 0);

    // R4 R10: two back-to-back two-cycle writes
    cfgTwoCycle = 1'b1; cfgAddrSize = 2'd1; cfgDataSize = 2'd0;
    base = edgeTotal;
    doWrite(20'h00003, 32'h00000011);
    check(reqReady == 1'b0, "R10 ready low while busy", longint'(reqReady), 0);
    doWrite(20'h00005, 32'h00000022);
    waitIdle();
    check(edgeTotal - base == 4, "R4 back-to-back edge count", longint'(edgeTotal - base), 4);
    check(recWr[8'(base + 2)] == 1'b1 && recPins[8'(base + 2)] == 32'h00000500,
          "R4 second address right after data", longint'(recPins[8'(base + 2)]), 32'h500);
    check(recWr[8'(base + 3)] == 1'b0 && recPins[8'(base + 3)] == 32'h00000022,
          "R4 second data", longint'(recPins[8'(base + 3)]), 32'h22);

    // R2 R10: back-to-back single-cycle writes need only one lead-in
    cfgTwoCycle = 1'b0;
    base = edgeTotal;
    doWrite(20'h00001, 32'h000000A1);
    doWrite(20'h00002, 32'h000000B2);
    waitIdle();
    check(edgeTotal - base == 3, "R2 one lead-in for a burst", longint'(edgeTotal - base), 3);
    check(recWr[8'(base + 2)] == 1'b1 && recPins[8'(base + 2)] == 32'h000002B2,
          "R10 second single write", longint'(recPins[8'(base + 2)]), 32'h2B2);

    // R6: divider zero overrides gating -> free running, period 2
    cfgClkDiv = 4'd0;
    @(negedge clk);
    base = edgeTotal;
    repeat (20) @(negedge clk);
    check(edgeTotal - base == 10, "R6 div zero free running", longint'(edgeTotal - base), 10);

    // R6: gating off, half-period cfgClkDiv+1 = 3 clocks -> 60 ns period
    cfgClkGate = 1'b0; cfgClkDiv = 4'd2;
    repeat (10) @(negedge clk);
    base = edgeTotal;
    repeat (20) @(negedge clk);
    check(edgeTotal - base >= 2 &&
          (recTime[8'(base + 1)] - recTime[base[7:0]]) == 60,
          "R6 free-running period", longint'(recTime[8'(base + 1)] - recTime[base[7:0]]), 60);

    // R7 R8: clock output disabled, 32-bit data legal, write still completes
    cfgClkOut = 1'b0; cfgClkGate = 1'b1; cfgClkDiv = 4'd1;
    cfgAddrSize = 2'd0; cfgDataSize = 2'd3;
    base = edgeTotal;
    doWrite(20'h00000, 32'hC001D00D);
    begin
      int seen = 0;
      logic [31:0] pinsSeen = '0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (busWr && seen == 0) begin seen = 1; pinsSeen = busPins; end
      end
      check(seen == 1 && pinsSeen == 32'hC001D00D, "R7 R8 write without clock",
            longint'(pinsSeen), 32'hC001D00D);
    end
    check(edgeTotal == base && reqReady == 1'b1, "R7 clock held low",
          longint'(edgeTotal - base), 0);
    check(cfgError == 1'b0, "R9 32-bit data legal without clock", longint'(cfgError), 0);

    // R9: 32-bit data with the clock enabled is illegal
    cfgClkOut = 1'b1;
    repeat (2) @(negedge clk);
    check(cfgError == 1'b1 && reqReady == 1'b0, "R9 wide data with clock",
          longint'(cfgError), 1);

    // R9: oversize address+data, sticky across a return to legal settings
    cfgDataSize = 2'd0;
    doReset();
    check(cfgError == 1'b0, "R9 cleared by reset", longint'(cfgError), 0);
    cfgAddrSize = 2'd2; cfgDataSize = 2'd2;
    repeat (2) @(negedge clk);
    check(cfgError == 1'b1, "R9 12-bit address with 24-bit data", longint'(cfgError), 1);
    cfgAddrSize = 2'd1; cfgDataSize = 2'd0;
    base = edgeTotal;
    reqValid = 1'b1;
    begin
      int wrSeen = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (busWr || reqReady) wrSeen++;
      end
      check(wrSeen == 0 && edgeTotal == base, "R9 requests refused", longint'(wrSeen), 0);
    end
    reqValid = 1'b0;
    check(cfgError == 1'b1, "R9 error sticky", longint'(cfgError), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule